// File: doc/BRIEF.md
# Timed Register Write-Lock Controller

This block guards a bank of configuration registers against stray software writes. Software finishes its setup and then writes a two-word key to a lock-control register. The first word arms the controller. The second word must follow within a short window of clock cycles. When it does, the controller enters a locked state. From then on it refuses every software write to the protected bank, and only a hardware reset releases it.

The block sits beside the register file. It observes every write strobe. For each protected register it produces a write-allow that the register file uses to gate its own enable. It also serves a read path that reports the lock status. The contents of the protected registers are not part of this block.

All interfaces are plain and single-cycle. A write is taken on the clock edge where `wr_en` is high. There is no valid/ready handshake and no back-pressure: the controller never stalls or refuses a strobe. Reads are combinational from `rd_addr`.

Top module: `wlock_ctrl`

## Requirements
- R1: After reset, `locked` is 0, the controller is not armed, and reading the lock-control address returns 0.
- R2: The lock-control register sits at address `LOCK_ADDR` (default 0x10). Only data bits 1:0 are examined: bit 1 is the enable bit and bit 0 is the lock bit. A write whose bits 1:0 are 2'b11 arms the controller, and `locked` stays 0.
- R3: While armed, a write of bits 1:0 = 2'b01 raises `locked` from the next cycle. The write counts if it lands on the edge 1, 2, 3 or 4 cycles (`WINDOW`) after the arming edge.
- R4: If no lock-control write arrives within `WINDOW` edges after arming, the arming lapses. A later 2'b01 write then leaves `locked` at 0.
- R5: While armed, a lock-control write whose bits 1:0 are 2'b00 or 2'b10 cancels the arming. A following 2'b01 write does not lock.
- R6: While armed, a new 2'b11 write re-arms and restarts the window from that edge.
- R7: While locked, every bit of `wr_allow` is 0. Lock-control writes have no effect on the state.
- R8: Once set, `locked` stays 1 until `rst_n` is asserted low.
- R9: When unlocked, `wr_allow[i]` is 1 exactly when `wr_en` is high and `wr_addr` equals `PROT_BASE + i` (default base 0x00, six slots).
- R10: `rd_data` returns `{0..., locked}` when `rd_addr` equals `LOCK_ADDR`, and all zeros for any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (lock status at LOCK_ADDR) |
| wr_allow | output | NUM_PROT | Per-slot write permission for the protected bank |
| locked | output | 1 | Lock status, sticky until reset |

## Verification
The embedded properties check on every cycle that the lock never drops, that `wr_allow` stays dark while locked, and that any rise of `locked` follows an armed-state 2'b01 write. They also check that the window counter stays within 1..`WINDOW` while armed, that at most one slot is allowed at a time, and that the upper read bits are zero. The exact deadline can only be shown by the bench's timed sequences: the fourth-cycle write succeeds and the fifth fails. The same holds for cancellation by a wrong pattern, re-arming that restarts the window, and release by reset.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,
    LK_ARMED  = 2'd1,
    LK_LOCKED = 2'd2
  } lk_state_e;

  // key codes on data bits [1:0]: {enable, lock}
  localparam logic [1:0] KEY_ARM  = 2'b11;
  localparam logic [1:0] KEY_SEAL = 2'b01;

endpackage

// File: rtl/wlock_decode.sv
module wlock_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_PROT  = 6,
  parameter int PROT_BASE = 0,
  parameter int LOCK_ADDR = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                locked,
  output logic                lock_wr,
  output logic [NUM_PROT-1:0] allow
);

  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

  assign lock_wr = wr_en && (wr_addr == LOCK_A);

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(PROT_BASE + g);
    assign allow[g] = wr_en && (wr_addr == SLOT_A) && !locked;
  end

  // R9: distinct slot addresses never grant two slots at once
  assert_allow_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(allow));

endmodule

// File: rtl/wlock_seq.sv
module wlock_seq
  import wlock_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_wr,
  input  logic [1:0] key,
  output logic       locked
);

  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] WIN_C = CW'(WINDOW);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  lk_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      LK_IDLE: begin
        cnt_d = '0;
        if (lock_wr && key == KEY_ARM) begin
          state_d = LK_ARMED;
          cnt_d   = ONE_C;
        end
      end
      LK_ARMED: begin
        if (lock_wr) begin
          if (key == KEY_SEAL) begin
            state_d = LK_LOCKED;
            cnt_d   = '0;
          end else if (key == KEY_ARM) begin
            cnt_d   = ONE_C;
          end else begin
            state_d = LK_IDLE;
            cnt_d   = '0;
          end
        end else if (cnt_q == WIN_C) begin
          state_d = LK_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d   = cnt_q + ONE_C;
        end
      end
      LK_LOCKED: begin
        cnt_d = '0;
      end
      default: begin
        state_d = LK_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign locked = (state_q == LK_LOCKED);

  // R8: lock is sticky until reset
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R3: lock only rises after an armed-state seal write
  assert_seal_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(state_q == LK_ARMED && lock_wr && key == KEY_SEAL));

  // R4: window counter stays within 1..WINDOW while armed
  assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_ARMED) |-> (cnt_q >= ONE_C && cnt_q <= WIN_C));

endmodule

// File: rtl/wlock_rdmux.sv
module wlock_rdmux #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int LOCK_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              locked,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

  always_comb begin
    rd_data = '0;
    if (rd_addr == LOCK_A) rd_data[0] = locked;
  end

  // R10: only bit 0 of the status word may be set
  assert_rd_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:1] == '0);

endmodule

// File: rtl/wlock_ctrl.sv
module wlock_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_PROT  = 6,
  parameter int PROT_BASE = 0,
  parameter int LOCK_ADDR = 16,
  parameter int WINDOW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_PROT-1:0] wr_allow,
  output logic                locked
);

  logic lock_wr;
  logic data_unused;

  // only the key bits take part in the sequence
  assign data_unused = ^wr_data[DATA_W-1:2];

  wlock_decode #(
    .ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT),
    .PROT_BASE(PROT_BASE), .LOCK_ADDR(LOCK_ADDR)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .locked(locked), .lock_wr(lock_wr), .allow(wr_allow)
  );

  wlock_seq #(.WINDOW(WINDOW)) u_seq (
    .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr),
    .key(wr_data[1:0]), .locked(locked)
  );

  wlock_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR)
  ) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr),
    .locked(locked), .rd_data(rd_data)
  );

  // R7: no protected write may pass while locked
  assert_allow_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (wr_allow == '0));

endmodule

// File: tb/tb_wlock_ctrl.sv
`timescale 1ns/1ps
module tb_wlock_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0] wr_allow;
  logic       locked;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wlock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_allow(wr_allow), .locked(locked)
  );

  typedef struct packed {
    logic       rst;
    logic       en;
    logic [7:0] addr;
    logic [7:0] data;
    logic [5:0] allow;
    logic       lock;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 8'h00, 8'h00, 6'b000000, 1'b0}, // reset
    '{1'b0, 1'b1, 8'h00, 8'hAA, 6'b000001, 1'b0}, // R9 slot 0
    '{1'b0, 1'b1, 8'h10, 8'h03, 6'b000000, 1'b0}, // R2 arm
    '{1'b0, 1'b0, 8'h00, 8'h00, 6'b000000, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 6'b000000, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 6'b000000, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 6'b000000, 1'b0}, // window lapses
    '{1'b0, 1'b1, 8'h10, 8'h01, 6'b000000, 1'b0}, // R4 late seal
    '{1'b0, 1'b1, 8'h10, 8'h03, 6'b000000, 1'b0}, // arm
    '{1'b0, 1'b1, 8'h10, 8'h02, 6'b000000, 1'b0}, // R5 wrong key
    '{1'b0, 1'b1, 8'h10, 8'h01, 6'b000000, 1'b0}, // R5 seal after cancel
    '{1'b0, 1'b1, 8'h10, 8'h03, 6'b000000, 1'b0}, // arm
    '{1'b0, 1'b0, 8'h00, 8'h00, 6'b000000, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 6'b000000, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 6'b000000, 1'b0},
    '{1'b0, 1'b1, 8'h10, 8'h01, 6'b000000, 1'b1}, // R3 seal on 4th
    '{1'b0, 1'b1, 8'h05, 8'h55, 6'b000000, 1'b1}, // R7 blocked
    '{1'b0, 1'b1, 8'h10, 8'h00, 6'b000000, 1'b1}, // R8 sticky
    '{1'b1, 1'b0, 8'h00, 8'h00, 6'b000000, 1'b0}, // R8 reset clears
    '{1'b0, 1'b1, 8'h05, 8'h55, 6'b100000, 1'b0}  // R9 slot 5
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    // vector table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rst_n   = !VT[i].rst;
      wr_en   = VT[i].en;
      wr_addr = VT[i].addr;
      wr_data = VT[i].data;
      #0.5;
      check($sformatf("R9/R7 allow row %0d", i), int'(wr_allow), int'(VT[i].allow));
      @(posedge clk);
      #1;
      check($sformatf("R3/R4/R5/R8 lock row %0d", i), int'(locked), int'(VT[i].lock));
    end
    @(negedge clk);
    rst_n = 1'b1; wr_en = 1'b0;

    // R1: reset state
    do_reset();
    rd_addr = 8'h10; #0.5;
    check("R1 locked after reset", int'(locked), 0);
    check("R1 read after reset", int'(rd_data), 0);

    // R3: seal on the very next cycle; bits above [1:0] ignored (R2)
    wr(8'h10, 8'hF3);
    check("R2 arm only", int'(locked), 0);
    wr(8'h10, 8'hFD);
    check("R3 seal k=1", int'(locked), 1);
    check("R10 read locked", int'(rd_data), 1);
    rd_addr = 8'h05; #0.5;
    check("R10 other addr", int'(rd_data), 0);

    // R7: lock-control writes ignored, all slots dark
    wr(8'h10, 8'h03);
    wr(8'h10, 8'h00);
    check("R7 lock holds", int'(locked), 1);
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'(s); #0.5;
      check($sformatf("R7 slot %0d dark", s), int'(wr_allow), 0);
      wr_en = 1'b0;
    end

    // R6: re-arm restarts the window
    do_reset();
    wr(8'h10, 8'h03);
    idle(3);
    wr(8'h10, 8'h03);
    idle(3);
    check("R6 not yet", int'(locked), 0);
    wr(8'h10, 8'h01);
    check("R6 seal after re-arm", int'(locked), 1);

    // R5: 2'b00 cancels
    do_reset();
    wr(8'h10, 8'h03);
    wr(8'h10, 8'h00);
    wr(8'h10, 8'h01);
    check("R5 cancel by 00", int'(locked), 0);

    // R4: seal on 5th cycle is late
    wr(8'h10, 8'h03);
    idle(4);
    wr(8'h10, 8'h01);
    check("R4 late k=5", int'(locked), 0);

    // R9: address just above bank is not a slot
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h06; #0.5;
    check("R9 out of bank", int'(wr_allow), 0);
    wr_addr = 8'h02; #0.5;
    check("R9 slot 2", int'(wr_allow), 4);
    wr_en = 1'b0; #0.5;
    check("R9 no strobe", int'(wr_allow), 0);

    summary();
  end

endmodule